// File: doc/BRIEF.md
# Auto-Stepping External Memory Port

This block gives a small DSP core access to a large external word memory through a handful of access registers. Each access register holds two stored configurations: one for reads and one for writes. A configuration is an address word together with a mode word. After a configuration is set, every read or write through that register becomes a transfer on the external bus. The stored address then advances by an amount that the mode selects.

Configurations are set through a separate control register, using a two-step handshake. The core writes the control register twice: the address word first, then the mode word. The next access to any access register is a configuring access. It moves the pending pair into that register's read configuration if it is a read, or into its write configuration if it is a write. It does not transfer any data. One write mode merges data into memory nibble by nibble: nibbles that are zero in the data keep their old value. This takes a read-modify-write on the bus. Two write modes step the address in a tile-aware way.

The external memory is a plain synchronous word bus with a one-cycle read latency. A separate flag marks reads aimed at the program ROM region. The core must not start a new access while `busy` is high. Arbitration with other bus masters is handled outside this block.

Top module: `xmem_port`

## Requirements
- R1: Register select values 0 to 4 address the access registers and value 5 addresses the control register. Control writes alternate between an address transfer and a mode transfer. A later access to an access register latches the pending pair into its read configuration (on a read) or its write configuration (on a write). That access causes no bus strobe, and if it is a read it returns 0 one cycle later.
- R2: The external word address is the low 7 bits of the mode word, placed above the 16-bit stored address.
- R3: Write mode 0x0018 writes the data and leaves the address unchanged. Write mode 0x0818 writes the data and then adds 1 to the address.
- R4: Write mode 0x4018 writes the data, then adds 31 to the address if it was odd, or 1 if it was even.
- R5: Write modes 0x0418 and 0x4418 read the old word first. Each 4-bit nibble of the data that is nonzero replaces the matching old nibble, and the other nibbles keep their old value. Mode 0x0418 does not step the address; mode 0x4418 uses the R4 step.
- R6: Read modes return the word at the current address and then step the address: 0x0018 by 0, 0x0818 by +1, 0x3018 by +32, 0xA818 by -16, and 0xB818 by -128. The address wraps within 16 bits.
- R7: A read mode whose bits 15:4 equal 0x080 raises `mem_rom` and reads at address {3'b000, mode[3:0], addr}. It then adds 1 to the address.
- R8: When both `route_bits` are 0, access registers 0 to 3 act as plain 16-bit storage and cause no bus strobes. Register 4 always acts as a memory port, and any nonzero `route_bits` makes all five registers memory ports.
- R9: An access to an access register that arrives when only the address transfer has been made cancels the handshake. The access itself then goes ahead as a normal access, so the next control write is taken as an address again.
- R10: A control register read returns the current (stepped) address word of the configuration used most recently, and it leaves the handshake untouched. After reset this value is 0.
- R11: A port access whose configuration mode is not one listed in R3 to R7 causes no bus strobe and does not step the address. Such a read returns 0 after one cycle.
- R12: A memory read returns `rsp_valid` three falling-edge samples after its request is raised, and `busy` stays high meanwhile. A request made while `busy` is high is ignored. `mem_re` and `mem_we` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| route_bits | input | 2 | Status bits; both 0 turns registers 0 to 3 into plain storage |
| req_rd | input | 1 | Read request, one cycle |
| req_wr | input | 1 | Write request, one cycle; wins over req_rd |
| req_sel | input | 3 | Register select: 0 to 4 access registers, 5 control |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_data | output | 16 | Read data |
| busy | output | 1 | A memory operation is in flight |
| mem_addr | output | 23 | External word address |
| mem_rom | output | 1 | Read is aimed at the ROM region |
| mem_re | output | 1 | External read strobe |
| mem_we | output | 1 | External write strobe |
| mem_wdata | output | 16 | External write data |
| mem_rdata | input | 16 | External read data, valid the cycle after mem_re |

## Verification
The bench targets these corner cases:
- **Odd addresses in the tile modes.** A design that steps by +1 always would put the second word 30 words too low.
- **Nibble merge with zero nibbles in the data.** A design that writes the whole word would wipe out old nibbles. One that skips the prior read would merge against stale data.
- **A configuring access arriving after only the address.** Without the abort, the following control write would be taken as a mode word, so a later configuration would target the wrong address.
- **Address wrap at 0xFFFF in a ROM read, the plain-register mode, and requests made while busy.** If any of these is handled wrongly, a transfer shows up that should not, or a stored value changes that should not.

// File: rtl/xmp_pkg.sv
package xmp_pkg;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_ADDR  = 2'd1,
    HS_READY = 2'd2
  } hs_t;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_RD1  = 3'd1,
    SQ_RD2  = 3'd2,
    SQ_MG1  = 3'd3,
    SQ_MG2  = 3'd4
  } sq_t;

  // write modes
  localparam logic [15:0] WM_HOLD      = 16'h0018;
  localparam logic [15:0] WM_INC       = 16'h0818;
  localparam logic [15:0] WM_TILE      = 16'h4018;
  localparam logic [15:0] WM_MERGE     = 16'h0418;
  localparam logic [15:0] WM_MERGE_T   = 16'h4418;
  // read modes
  localparam logic [15:0] RM_HOLD      = 16'h0018;
  localparam logic [15:0] RM_INC       = 16'h0818;
  localparam logic [15:0] RM_P32       = 16'h3018;
  localparam logic [15:0] RM_M16       = 16'hA818;
  localparam logic [15:0] RM_M128      = 16'hB818;
  localparam logic [11:0] RM_ROM_TOP   = 12'h080;

endpackage

// File: rtl/xmp_mode_dec.sv
module xmp_mode_dec
  import xmp_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [15:0]   mode,
  input  logic          is_wr,
  input  logic [AW-1:0] addr,
  output logic          legal,
  output logic          merge,
  output logic          rom,
  output logic [AW-1:0] next_addr
);

  logic [AW-1:0] delta;
  logic [AW-1:0] tile;

  assign tile = addr[0] ? AW'(31) : AW'(1);

  always_comb begin
    legal = 1'b1;
    merge = 1'b0;
    rom   = 1'b0;
    delta = '0;
    if (is_wr) begin
      case (mode)
        WM_HOLD:    delta = '0;
        WM_INC:     delta = AW'(1);
        WM_TILE:    delta = tile;
        WM_MERGE:   merge = 1'b1;
        WM_MERGE_T: begin merge = 1'b1; delta = tile; end
        default:    legal = 1'b0;
      endcase
    end else if (mode[15:4] == RM_ROM_TOP) begin
      rom   = 1'b1;
      delta = AW'(1);
    end else begin
      case (mode)
        RM_HOLD: delta = '0;
        RM_INC:  delta = AW'(1);
        RM_P32:  delta = AW'(32);
        RM_M16:  delta = AW'(0) - AW'(16);
        RM_M128: delta = AW'(0) - AW'(128);
        default: legal = 1'b0;
      endcase
    end
  end

  assign next_addr = addr + delta;

endmodule

// File: rtl/xmp_handshake.sv
module xmp_handshake
  import xmp_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_wr,
  input  logic [DW-1:0] ctl_data,
  input  logic          acc_hit,
  output hs_t           state,
  output logic [AW-1:0] addr_q,
  output logic [15:0]   mode_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= HS_IDLE;
      addr_q <= '0;
      mode_q <= '0;
    end else if (ctl_wr) begin
      if (state == HS_ADDR) begin
        mode_q <= 16'(ctl_data);
        state  <= HS_READY;
      end else begin
        addr_q <= AW'(ctl_data);
        state  <= HS_ADDR;
      end
    end else if (acc_hit) begin
      // consumes a ready pair, or cancels a half-done handshake
      state <= HS_IDLE;
    end
  end

  p_addr_first_r1: assert property (@(posedge clk) disable iff (rst)
    (state == HS_IDLE && ctl_wr) |=> (state == HS_ADDR));

  p_ready_after_addr_r1: assert property (@(posedge clk) disable iff (rst)
    (state == HS_READY && $past(state) != HS_READY) |-> ($past(state) == HS_ADDR));

  p_cancel_half_r9: assert property (@(posedge clk) disable iff (rst)
    (state == HS_ADDR && acc_hit && !ctl_wr) |=> (state == HS_IDLE));

endmodule

// File: rtl/xmp_cfg_bank.sv
module xmp_cfg_bank #(
  parameter int NPORT = 5,
  parameter int AW    = 16,
  parameter int IW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [IW-1:0] ld_idx,
  input  logic          ld_wr,
  input  logic [AW-1:0] ld_addr,
  input  logic [15:0]   ld_mode,
  input  logic          st_en,
  input  logic [IW-1:0] st_idx,
  input  logic          st_wr,
  input  logic [AW-1:0] st_addr,
  input  logic [IW-1:0] rd_idx,
  input  logic          rd_wr,
  output logic [AW-1:0] rd_addr,
  output logic [15:0]   rd_mode,
  input  logic [IW-1:0] lu_idx,
  input  logic          lu_wr,
  output logic [AW-1:0] lu_addr
);

  logic [AW-1:0] rcfg_a [NPORT];
  logic [AW-1:0] wcfg_a [NPORT];
  logic [15:0]   rcfg_m [NPORT];
  logic [15:0]   wcfg_m [NPORT];

  for (genvar g = 0; g < NPORT; g++) begin : g_slot
    logic [AW-1:0] ra_q, wa_q;
    logic [15:0]   rm_q, wm_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        ra_q <= '0; wa_q <= '0; rm_q <= '0; wm_q <= '0;
      end else if (ld_en && ld_idx == IW'(g)) begin
        if (ld_wr) begin wa_q <= ld_addr; wm_q <= ld_mode; end
        else       begin ra_q <= ld_addr; rm_q <= ld_mode; end
      end else if (st_en && st_idx == IW'(g)) begin
        if (st_wr) wa_q <= st_addr;
        else       ra_q <= st_addr;
      end
    end
    assign rcfg_a[g] = ra_q;
    assign wcfg_a[g] = wa_q;
    assign rcfg_m[g] = rm_q;
    assign wcfg_m[g] = wm_q;
  end

  always_comb begin
    rd_addr = '0;
    rd_mode = '0;
    lu_addr = '0;
    for (int i = 0; i < NPORT; i++) begin
      if (rd_idx == IW'(i)) begin
        rd_addr = rd_wr ? wcfg_a[i] : rcfg_a[i];
        rd_mode = rd_wr ? wcfg_m[i] : rcfg_m[i];
      end
      if (lu_idx == IW'(i)) lu_addr = lu_wr ? wcfg_a[i] : rcfg_a[i];
    end
  end

endmodule

// File: rtl/xmem_port.sv
module xmem_port
  import xmp_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int HI_W  = 7,
  parameter int NPORT = 5,
  localparam int SW   = $clog2(NPORT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         route_bits,
  input  logic               req_rd,
  input  logic               req_wr,
  input  logic [SW-1:0]      req_sel,
  input  logic [DW-1:0]      req_wdata,
  output logic               rsp_valid,
  output logic [DW-1:0]      rsp_data,
  output logic               busy,
  output logic [HI_W+AW-1:0] mem_addr,
  output logic               mem_rom,
  output logic               mem_re,
  output logic               mem_we,
  output logic [DW-1:0]      mem_wdata,
  input  logic [DW-1:0]      mem_rdata
);

  localparam int NPLAIN = NPORT - 1;
  localparam int PW     = (NPLAIN > 1) ? $clog2(NPLAIN) : 1;
  localparam int NIB    = DW / 4;

  hs_t           hs_state;
  logic [AW-1:0] hs_addr;
  logic [15:0]   hs_mode;
  logic [AW-1:0] cur_addr, next_addr, lu_addr;
  logic [15:0]   cur_mode;
  logic          legal, merge, rom;
  logic [SW-1:0] lu_idx;
  logic          lu_wr;
  sq_t           sq;
  logic [DW-1:0] hold_q, merged;
  logic [DW-1:0] plain_q [NPLAIN];

  logic take, is_ctl, is_acc, acc_hit, cfg_take, normal, port_on, plain;

  assign take     = (req_rd | req_wr) & ~busy;
  assign is_ctl   = (req_sel == SW'(NPORT));
  assign is_acc   = (req_sel < SW'(NPORT));
  assign acc_hit  = take & is_acc;
  assign cfg_take = acc_hit & (hs_state == HS_READY);
  assign normal   = acc_hit & ~cfg_take;
  assign port_on  = normal & ((req_sel == SW'(NPORT - 1)) | (|route_bits));
  assign plain    = normal & ~port_on;

  xmp_handshake #(.AW(AW), .DW(DW)) u_hs (
    .clk      (clk),
    .rst      (rst),
    .ctl_wr   (take & is_ctl & req_wr),
    .ctl_data (req_wdata),
    .acc_hit  (acc_hit),
    .state    (hs_state),
    .addr_q   (hs_addr),
    .mode_q   (hs_mode)
  );

  xmp_cfg_bank #(.NPORT(NPORT), .AW(AW), .IW(SW)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .ld_en   (cfg_take),
    .ld_idx  (req_sel),
    .ld_wr   (req_wr),
    .ld_addr (hs_addr),
    .ld_mode (hs_mode),
    .st_en   (port_on & legal),
    .st_idx  (req_sel),
    .st_wr   (req_wr),
    .st_addr (next_addr),
    .rd_idx  (req_sel),
    .rd_wr   (req_wr),
    .rd_addr (cur_addr),
    .rd_mode (cur_mode),
    .lu_idx  (lu_idx),
    .lu_wr   (lu_wr),
    .lu_addr (lu_addr)
  );

  xmp_mode_dec #(.AW(AW)) u_dec (
    .mode      (cur_mode),
    .is_wr     (req_wr),
    .addr      (cur_addr),
    .legal     (legal),
    .merge     (merge),
    .rom       (rom),
    .next_addr (next_addr)
  );

  always_comb begin
    merged = mem_rdata;
    for (int i = 0; i < NIB; i++)
      if (|hold_q[4*i +: 4]) merged[4*i +: 4] = hold_q[4*i +: 4];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sq        <= SQ_IDLE;
      busy      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      mem_addr  <= '0;
      mem_rom   <= 1'b0;
      mem_re    <= 1'b0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      hold_q    <= '0;
      lu_idx    <= '0;
      lu_wr     <= 1'b0;
      for (int i = 0; i < NPLAIN; i++) plain_q[i] <= '0;
    end else begin
      rsp_valid <= 1'b0;
      mem_re    <= 1'b0;
      mem_we    <= 1'b0;
      if (cfg_take || port_on) begin
        lu_idx <= req_sel;
        lu_wr  <= req_wr;
      end
      case (sq)
        SQ_IDLE: begin
          if (take && !req_wr) begin
            if (is_ctl) begin
              rsp_data  <= DW'(lu_addr);
              rsp_valid <= 1'b1;
            end else if (plain) begin
              rsp_data  <= plain_q[req_sel[PW-1:0]];
              rsp_valid <= 1'b1;
            end else if (port_on && legal) begin
              mem_addr <= {cur_mode[HI_W-1:0], cur_addr};
              mem_rom  <= rom;
              mem_re   <= 1'b1;
              busy     <= 1'b1;
              sq       <= SQ_RD1;
            end else begin
              // configuring access or unsupported mode
              rsp_data  <= '0;
              rsp_valid <= 1'b1;
            end
          end else if (take && req_wr) begin
            if (plain) begin
              plain_q[req_sel[PW-1:0]] <= req_wdata;
            end else if (port_on && legal) begin
              mem_addr <= {cur_mode[HI_W-1:0], cur_addr};
              mem_rom  <= 1'b0;
              if (merge) begin
                hold_q <= req_wdata;
                mem_re <= 1'b1;
                busy   <= 1'b1;
                sq     <= SQ_MG1;
              end else begin
                mem_wdata <= req_wdata;
                mem_we    <= 1'b1;
              end
            end
          end
        end
        SQ_RD1: sq <= SQ_RD2;
        SQ_RD2: begin
          rsp_data  <= mem_rdata;
          rsp_valid <= 1'b1;
          busy      <= 1'b0;
          sq        <= SQ_IDLE;
        end
        SQ_MG1: sq <= SQ_MG2;
        SQ_MG2: begin
          mem_wdata <= merged;
          mem_we    <= 1'b1;
          busy      <= 1'b0;
          sq        <= SQ_IDLE;
        end
        default: sq <= SQ_IDLE;
      endcase
    end
  end

  p_strobe_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we));

  p_re_single_r12: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> (!mem_re && busy));

  p_plain_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    plain |=> (!mem_re && !mem_we));

  p_cfg_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    cfg_take |=> (!mem_re && !mem_we));

  p_bad_mode_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (port_on && !legal) |=> (!mem_re && !mem_we));

  p_merge_same_addr_r5: assert property (@(posedge clk) disable iff (rst)
    (sq == SQ_MG2) |=> (mem_we && $stable(mem_addr)));

endmodule

// File: tb/sim_xmem_port.sv
`timescale 1ns/1ps
module sim_xmem_port;

  localparam int CTL = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  route = 2'b11;
  logic        req_rd = 1'b0, req_wr = 1'b0;
  logic [2:0]  req_sel = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid, busy, mem_rom, mem_re, mem_we;
  logic [15:0] rsp_data, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic [22:0] mem_addr;

  xmem_port u0 (
    .clk(clk), .rst(rst), .route_bits(route), .req_rd(req_rd), .req_wr(req_wr),
    .req_sel(req_sel), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .busy(busy), .mem_addr(mem_addr), .mem_rom(mem_rom), .mem_re(mem_re), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  logic [15:0] mem_m [int];
  logic [15:0] shd [int];
  int we_cnt = 0, re_cnt = 0;
  logic [22:0] last_wa = '0;
  logic last_rom = 1'b0;

  function automatic logic [15:0] romf(logic [22:0] a);
    return (a[15:0] ^ 16'hA5C3) + {9'd0, a[22:16]};
  endfunction

  always @(posedge clk) begin
    if (mem_we) begin
      mem_m[int'(mem_addr)] = mem_wdata;
      we_cnt++;
      last_wa = mem_addr;
    end
    if (mem_re) begin
      re_cnt++;
      last_rom = mem_rom;
      if (mem_rom) mem_rdata <= romf(mem_addr);
      else if (mem_m.exists(int'(mem_addr))) mem_rdata <= mem_m[int'(mem_addr)];
      else mem_rdata <= 16'h0;
    end
  end

  function automatic logic [15:0] mem_get(logic [22:0] a);
    return mem_m.exists(int'(a)) ? mem_m[int'(a)] : 16'h0;
  endfunction

  function automatic logic [15:0] shd_get(logic [22:0] a);
    return shd.exists(int'(a)) ? shd[int'(a)] : 16'h0;
  endfunction

  function automatic logic [15:0] nib_mix(logic [15:0] old, logic [15:0] nw);
    logic [15:0] r = old;
    for (int i = 0; i < 4; i++) if (nw[4*i +: 4] != 4'h0) r[4*i +: 4] = nw[4*i +: 4];
    return r;
  endfunction

  function automatic logic [15:0] exp_next(logic [15:0] m, bit wr, logic [15:0] a);
    if (wr) begin
      if (m == 16'h0818) return a + 16'd1;
      if (m == 16'h4018 || m == 16'h4418) return a + (a[0] ? 16'd31 : 16'd1);
      return a;
    end
    if (m[15:4] == 12'h080) return a + 16'd1;
    case (m)
      16'h0818: return a + 16'd1;
      16'h3018: return a + 16'd32;
      16'hA818: return a - 16'd16;
      16'hB818: return a - 16'd128;
      default:  return a;
    endcase
  endfunction

  function automatic string wtag(logic [15:0] m);
    if (m == 16'h4018) return "R4";
    if (m == 16'h0418 || m == 16'h4418) return "R5";
    return "R3";
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  task automatic bus_wr(int sel, logic [15:0] d);
    @(negedge clk);
    while (busy) @(negedge clk);
    req_wr = 1'b1; req_sel = 3'(sel); req_wdata = d;
    @(negedge clk);
    req_wr = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic bus_rd(int sel, output logic [15:0] d, output int lat);
    @(negedge clk);
    while (busy) @(negedge clk);
    req_rd = 1'b1; req_sel = 3'(sel);
    @(negedge clk);
    req_rd = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 20) begin @(negedge clk); lat++; end
    d = rsp_data;
  endtask

  task automatic cfg(int sel, bit wr, logic [15:0] a, logic [15:0] m);
    logic [15:0] d;
    int lat;
    bus_wr(CTL, a);
    bus_wr(CTL, m);
    if (wr) bus_wr(sel, 16'hFFFF);
    else bus_rd(sel, d, lat);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL R12 watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] d, a, ea, wm, rm, v, e;
    logic [22:0] full;
    int lat, w0, r0;
    logic [15:0] wmodes [5] = '{16'h0018, 16'h0818, 16'h4018, 16'h0418, 16'h4418};
    logic [15:0] rmodes [5] = '{16'h0018, 16'h0818, 16'h3018, 16'hA818, 16'hB818};
    int unsigned seed;
    seed = $urandom(32'd20240611);

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !rsp_valid && !mem_we && !mem_re, "R12 reset outputs",
        {busy, rsp_valid, mem_we, mem_re}, 0);
    bus_rd(CTL, v, lat);
    chk(v == 16'h0 && lat == 1, "R10 reset control read", {v, 16'(lat)}, 32'h1);

    // R1: configuring read returns 0, no strobes
    r0 = re_cnt; w0 = we_cnt;
    bus_wr(CTL, 16'h0010); bus_wr(CTL, 16'h0018);
    bus_rd(0, v, lat);
    chk(v == 0 && lat == 1 && re_cnt == r0 && we_cnt == w0, "R1 configuring read",
        {v, 8'(lat), 8'(re_cnt - r0)}, 32'h00000100);

    // R4 tile stepping from an odd address
    cfg(3, 1, 16'h0021, 16'h4018);
    bus_wr(3, 16'h1111);
    chk(last_wa == 23'h180021 && mem_get(23'h180021) == 16'h1111, "R4 odd write", last_wa, 23'h180021);
    bus_wr(3, 16'h2222);
    chk(last_wa == 23'h180040, "R4 step +31", last_wa, 23'h180040);
    bus_rd(CTL, v, lat);
    chk(v == 16'h0041, "R4 step +1 then R10", v, 16'h0041);
    shd[int'(23'h180021)] = 16'h1111; shd[int'(23'h180040)] = 16'h2222;

    // R5 merge
    cfg(2, 1, 16'h0040, 16'h0418);
    bus_wr(2, 16'hA0B0);
    e = 16'hA2B2;
    chk(mem_get(23'h180040) == e, "R5 nibble merge", mem_get(23'h180040), e);
    shd[int'(23'h180040)] = e;
    bus_rd(CTL, v, lat);
    chk(v == 16'h0040, "R5 merge holds address", v, 16'h0040);

    // R7 ROM read with wrap
    cfg(0, 0, 16'hFFFF, 16'h0805);
    bus_rd(0, v, lat);
    chk(v == romf(23'h05FFFF) && last_rom && lat == 3, "R7 rom read", v, romf(23'h05FFFF));
    bus_rd(0, v, lat);
    chk(v == romf(23'h050000), "R7 rom +1 wraps", v, romf(23'h050000));

    // R11 unsupported modes
    cfg(1, 1, 16'h0500, 16'h1234);
    w0 = we_cnt;
    bus_wr(1, 16'hAAAA);
    chk(we_cnt == w0, "R11 bad write mode no strobe", we_cnt - w0, 0);
    bus_rd(CTL, v, lat);
    chk(v == 16'h0500, "R11 bad mode no step", v, 16'h0500);
    cfg(1, 0, 16'h0600, 16'h0019);
    r0 = re_cnt;
    bus_rd(1, v, lat);
    chk(v == 0 && lat == 1 && re_cnt == r0, "R11 bad read mode", {v, 16'(lat)}, 32'h1);

    // R9 half handshake cancelled
    cfg(4, 1, 16'h0100, 16'h0818);
    bus_wr(CTL, 16'h0200);
    bus_wr(4, 16'h1357);
    chk(mem_get(23'h180100) == 16'h1357, "R9 access after address only", mem_get(23'h180100), 16'h1357);
    shd[int'(23'h180100)] = 16'h1357;
    cfg(4, 1, 16'h0300, 16'h0018);
    bus_wr(4, 16'h2468);
    chk(last_wa == 23'h180300 && mem_get(23'h180300) == 16'h2468, "R9 handshake restarts",
        last_wa, 23'h180300);
    shd[int'(23'h180300)] = 16'h2468;

    // R8 plain registers
    route = 2'b00;
    cfg(4, 1, 16'h0044, 16'h0818);
    bus_wr(4, 16'h0D0D);
    chk(mem_get(23'h180044) == 16'h0D0D, "R8 reg4 stays a port", mem_get(23'h180044), 16'h0D0D);
    shd[int'(23'h180044)] = 16'h0D0D;
    cfg(2, 1, 16'h0050, 16'h0018);
    w0 = we_cnt;
    bus_wr(2, 16'hBEEF);
    chk(we_cnt == w0, "R8 plain write quiet", we_cnt - w0, 0);
    bus_rd(2, v, lat);
    chk(v == 16'hBEEF && lat == 1, "R8 plain readback", v, 16'hBEEF);
    route = 2'b10;
    bus_wr(2, 16'h1111);
    chk(last_wa == 23'h180050 && mem_get(23'h180050) == 16'h1111, "R8 one route bit enables port",
        last_wa, 23'h180050);
    shd[int'(23'h180050)] = 16'h1111;

    // R12 latency and ignore-while-busy
    route = 2'b00;
    cfg(4, 0, 16'h0044, 16'h0018);
    @(negedge clk);
    req_rd = 1'b1; req_sel = 3'd4;
    @(negedge clk);
    req_rd = 1'b0;
    chk(busy && !rsp_valid, "R12 busy during read", {busy, rsp_valid}, 2'b10);
    req_wr = 1'b1; req_sel = 3'd2; req_wdata = 16'h7777;
    @(negedge clk);
    req_wr = 1'b0;
    chk(!rsp_valid, "R12 no early data", rsp_valid, 0);
    @(negedge clk);
    chk(rsp_valid && rsp_data == 16'h0D0D, "R12 data on third sample", rsp_data, 16'h0D0D);
    bus_rd(2, v, lat);
    chk(v == 16'hBEEF, "R12 request while busy ignored", v, 16'hBEEF);

    // random mix
    route = 2'b11;
    for (int it = 0; it < 30; it++) begin
      int p = $urandom_range(0, 4);
      wm = wmodes[$urandom_range(0, 4)];
      a = 16'($urandom);
      w0 = we_cnt;
      cfg(p, 1, a, wm);
      chk(we_cnt == w0, "R1 blind write no transfer", we_cnt - w0, 0);
      ea = a;
      for (int k = 0; k < 3; k++) begin
        int msk = $urandom_range(0, 15);
        d = 16'($urandom);
        for (int n = 0; n < 4; n++) if (msk[n]) d[4*n +: 4] = 4'h0;
        full = {wm[6:0], ea};
        e = (wm == 16'h0418 || wm == 16'h4418) ? nib_mix(shd_get(full), d) : d;
        bus_wr(p, d);
        shd[int'(full)] = e;
        chk(last_wa == full, "R2 address composition", last_wa, full);
        chk(mem_get(full) == e, wtag(wm), mem_get(full), e);
        ea = exp_next(wm, 1'b1, ea);
      end
      bus_rd(CTL, v, lat);
      chk(v == ea, "R10 stepped write address", v, ea);
      rm = rmodes[$urandom_range(0, 4)];
      cfg(p, 0, a, rm);
      ea = a;
      for (int k = 0; k < 2; k++) begin
        full = {rm[6:0], ea};
        bus_rd(p, v, lat);
        chk(v == shd_get(full) && lat == 3, "R6 read data", v, shd_get(full));
        ea = exp_next(rm, 1'b0, ea);
      end
      bus_rd(CTL, v, lat);
      chk(v == ea, "R6 read step", v, ea);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule